// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block is one programmable interrupt controller for eight request lines. Per-line strobes record pending requests. A priority resolver compares the pending, unmasked requests with the lines currently in service and raises a single interrupt output when a request should be taken. When the processor answers with an acknowledge strobe, the block returns an interrupt vector: the programmed vector base with the winning line number in its low bits.

Software configures and services the controller through a byte-wide port with two addresses, chosen by one address bit. A write to the even address with bit 4 set starts a short sequence of initialisation words. That sequence programs the vector base and, optionally, the auto-end-of-interrupt and special-fully-nested modes. Later even-address writes carry end-of-interrupt and rotation commands, or a mode command. The mode command selects which register the even address reads back, arms a polled read, or sets the special mask flag. A rotation offset moves which line holds top priority. The resolver and the end-of-interrupt commands share that offset.

A polled read replaces the acknowledge cycle. A single read returns the winning line, marked by bit 7, and retires that line.

Top module: `rotpic_core`

## Requirements
- R1: After reset, the request, in-service and mask registers, the rotation offset, the vector base and all mode flags are zero. The sequencer is in normal mode, `irq_out` is low, and reads return 0.
- R2: An even-address write with bit 4 set clears the mask register, the rotation offset, the special mask flag and the read select, and makes the sequencer wait for the vector base. Bit 0 of that word announces a fourth word. When bit 0 is 0, the write also clears special-fully-nested and auto-EOI mode.
- R3: During initialisation, the first odd-address write sets the vector base to data AND 0xF8. The second odd-address write is discarded. If a fourth word was announced, a third odd-address write sets special-fully-nested mode from bit 4 and auto-EOI mode from bit 1. The sequencer then returns to normal mode. In normal mode, an odd-address write loads the mask register.
- R4: An even-address write with bit 4 = 0 and bit 3 = 1 is a mode command. Bit 2 arms a one-shot poll. When bit 1 = 1, bit 0 becomes the read select (1 = in-service, 0 = request). When bit 6 = 1, bit 5 becomes the special mask flag.
- R5: Priority position p maps to line (p + offset) mod 8, and position 0 is the highest. The best unmasked request wins only when its position is strictly better than the best in-service position. `irq_out` is high exactly when a winner exists, and it follows register changes in the same cycle.
- R6: While `int_ack` is high, `int_vector` is base OR winning line, or base OR 7 when there is no winner. On the clock edge, the acknowledge sets the winner's in-service bit and clears its request bit.
- R7: In auto-EOI mode, an acknowledge leaves the winner's in-service bit clear. If rotate-on-auto-EOI is also set, the acknowledge sets the offset to winner + 1.
- R8: For commands with bits 4:3 = 00, the operation is selected by data bits 7:5. Operation 1 clears the highest-priority in-service bit. Operation 5 does the same and also sets the offset to that line + 1. Both do nothing when no line is in service.
- R9: Operation 3 clears the in-service bit of the line in bits 2:0. Operation 6 sets the offset to (bits 2:0) + 1. Operation 7 does both. Operations 0 and 4 clear and set rotate-on-auto-EOI. Operation 2 changes nothing.
- R10: A read while poll is armed returns 0x80 OR the winning line and clears that line's request and in-service bits. With no winner it returns 0x07. In both cases the poll is disarmed, so the next read is a normal read.
- R11: A normal read of the even address returns the in-service or request register, as chosen by the read select. A read of the odd address returns the mask register.
- R12: In special mask mode, in-service bits whose lines are masked take no part in the in-service priority. In special-fully-nested mode, the in-service bit of the cascade line (parameter, default 2) takes no part in it.
- R13: A request strobe sets its request bit on the clock edge. It takes precedence over a clear that happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register address bit (0 even, 1 odd) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq_set | input | LINES | Per-line request strobes |
| irq_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge strobe |
| int_vector | output | 8 | Vector for the current winner |

## Verification
A corrupted rotation offset or in-service bit does not show at once. It appears as a wrong line in `int_vector`, or as `irq_out` staying low, on the next cycle that has competing requests. The bench therefore checks `irq_out` and `int_vector` every cycle against a model, and each command is followed within one or two cycles by an access that exposes its effect. A sequencer stuck in the wrong state shows on the next odd-address write: the write either lands in the mask register, where a read sees it, or fails to change the vector base.

// File: rtl/rotpic_pkg.sv
package rotpic_pkg;
   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_BASE = 2'd1,
      SEQ_SKIP = 2'd2,
      SEQ_MODE = 2'd3
   } seq_state_t;

   typedef enum logic [2:0] {
      OP_ROT_OFF = 3'd0,
      OP_EOI_NS  = 3'd1,
      OP_NOP     = 3'd2,
      OP_EOI_SP  = 3'd3,
      OP_ROT_ON  = 3'd4,
      OP_ROT_NS  = 3'd5,
      OP_SET_PRI = 3'd6,
      OP_ROT_SP  = 3'd7
   } svc_op_t;
endpackage

// File: rtl/rotpic_prio_find.sv
module rotpic_prio_find #(
   parameter int LINES = 8,
   parameter int LW    = $clog2(LINES)
) (
   input  logic [LINES-1:0] mask,
   input  logic [LW-1:0]    offset,
   output logic [LW:0]      pos
);
   logic [LW-1:0] idx;

   always_comb begin
      pos = (LW+1)'(LINES);
      idx = '0;
      for (int p = LINES - 1; p >= 0; p--) begin
         idx = offset + LW'(p);
         if (mask[idx]) pos = (LW+1)'(p);
      end
   end
endmodule

// File: rtl/rotpic_resolver.sv
module rotpic_resolver #(
   parameter int LINES     = 8,
   parameter int CASC_LINE = 2,
   parameter int LW        = $clog2(LINES)
) (
   input  logic [LINES-1:0] irr,
   input  logic [LINES-1:0] imr,
   input  logic [LINES-1:0] isr,
   input  logic [LW-1:0]    offset,
   input  logic             smm,
   input  logic             sfnm,
   output logic             win_valid,
   output logic [LW-1:0]    win_line,
   output logic             top_valid,
   output logic [LW-1:0]    top_line
);
   localparam int NFIND = 3;

   logic [LINES-1:0] masks [NFIND];
   logic [LW:0]      pos   [NFIND];
   logic [LINES-1:0] isr_eff;

   always_comb begin
      isr_eff = isr;
      if (smm)  isr_eff = isr_eff & ~imr;
      if (sfnm) isr_eff[CASC_LINE] = 1'b0;
   end

   assign masks[0] = irr & ~imr;
   assign masks[1] = isr_eff;
   assign masks[2] = isr;

   for (genvar k = 0; k < NFIND; k++) begin : g_find
      rotpic_prio_find #(.LINES(LINES), .LW(LW)) u_find (
         .mask   (masks[k]),
         .offset (offset),
         .pos    (pos[k])
      );
   end

   assign win_valid = pos[0] < pos[1];
   assign win_line  = pos[0][LW-1:0] + offset;
   assign top_valid = pos[2] != (LW+1)'(LINES);
   assign top_line  = pos[2][LW-1:0] + offset;
endmodule

// File: rtl/rotpic_init_seq.sv
module rotpic_init_seq import rotpic_pkg::*; (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic want4_in,
   input  logic odd_wr,
   output logic in_run,
   output logic ld_base,
   output logic ld_mode
);
   seq_state_t st_q, st_n;
   logic       want4_q, want4_n;

   assign in_run  = st_q == SEQ_RUN;
   assign ld_base = odd_wr && st_q == SEQ_BASE;
   assign ld_mode = odd_wr && st_q == SEQ_MODE;

   always_comb begin
      st_n    = st_q;
      want4_n = want4_q;
      if (start) begin
         st_n    = SEQ_BASE;
         want4_n = want4_in;
      end else if (odd_wr) begin
         case (st_q)
            SEQ_BASE: st_n = SEQ_SKIP;
            SEQ_SKIP: st_n = want4_q ? SEQ_MODE : SEQ_RUN;
            SEQ_MODE: st_n = SEQ_RUN;
            default:  st_n = SEQ_RUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SEQ_RUN;
         want4_q <= 1'b0;
      end else begin
         st_q    <= st_n;
         want4_q <= want4_n;
      end
   end

   a_r3_skip_after_base: assert property (@(posedge clk) disable iff (!rst_n)
      ld_base |=> st_q == SEQ_SKIP);
   a_r3_run_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
      ld_mode |=> st_q == SEQ_RUN);
   a_r2_start_waits_base: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> st_q == SEQ_BASE);
endmodule

// File: rtl/rotpic_core.sv
module rotpic_core import rotpic_pkg::*; #(
   parameter int LINES     = 8,
   parameter int CASC_LINE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic [LINES-1:0] irq_set,
   output logic             irq_out,
   input  logic             int_ack,
   output logic [7:0]       int_vector
);
   localparam int         LW        = $clog2(LINES);
   localparam logic [7:0] BASE_MASK = 8'hFF << LW;
   localparam logic [LW-1:0] IDLE_LINE = LW'(LINES - 1);

   if (LINES < 2 || LINES > 8 || (1 << LW) != LINES) begin : g_bad_lines
      $error("rotpic_core: LINES must be a power of two from 2 to 8");
   end
   if (CASC_LINE < 0 || CASC_LINE >= LINES) begin : g_bad_casc
      $error("rotpic_core: CASC_LINE must name a line");
   end

   logic [LINES-1:0] irr_q, isr_q, imr_q, irr_n, isr_n, imr_n;
   logic [LW-1:0]    off_q, off_n;
   logic [7:0]       base_q, base_n;
   logic poll_q, rsel_q, smm_q, sfnm_q, aeoi_q, rot_q;
   logic poll_n, rsel_n, smm_n, sfnm_n, aeoi_n, rot_n;

   logic             win_valid, top_valid;
   logic [LW-1:0]    win_line, top_line, cmd_line;
   logic             seq_run, ld_base, ld_mode;
   logic             even_wr, odd_wr, init_wr, mode_wr, svc_wr;
   svc_op_t          op;

   assign even_wr  = bus_wr && !bus_addr;
   assign odd_wr   = bus_wr && bus_addr;
   assign init_wr  = even_wr && bus_wdata[4];
   assign mode_wr  = even_wr && !bus_wdata[4] && bus_wdata[3];
   assign svc_wr   = even_wr && bus_wdata[4:3] == 2'b00;
   assign cmd_line = bus_wdata[LW-1:0];
   assign op       = svc_op_t'(bus_wdata[7:5]);

   rotpic_init_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (init_wr),
      .want4_in (bus_wdata[0]),
      .odd_wr   (odd_wr),
      .in_run   (seq_run),
      .ld_base  (ld_base),
      .ld_mode  (ld_mode)
   );

   rotpic_resolver #(.LINES(LINES), .CASC_LINE(CASC_LINE), .LW(LW)) u_res (
      .irr       (irr_q),
      .imr       (imr_q),
      .isr       (isr_q),
      .offset    (off_q),
      .smm       (smm_q),
      .sfnm      (sfnm_q),
      .win_valid (win_valid),
      .win_line  (win_line),
      .top_valid (top_valid),
      .top_line  (top_line)
   );

   assign irq_out    = win_valid;
   assign int_vector = base_q | 8'(win_valid ? win_line : IDLE_LINE);

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (poll_q)
            bus_rdata = win_valid ? (8'h80 | 8'(win_line)) : 8'(IDLE_LINE);
         else if (bus_addr)
            bus_rdata = 8'(imr_q);
         else
            bus_rdata = rsel_q ? 8'(isr_q) : 8'(irr_q);
      end
   end

   always_comb begin
      irr_n = irr_q;  isr_n = isr_q;  imr_n = imr_q;  off_n = off_q;
      base_n = base_q; poll_n = poll_q; rsel_n = rsel_q; smm_n = smm_q;
      sfnm_n = sfnm_q; aeoi_n = aeoi_q; rot_n = rot_q;

      // acknowledge cycle
      if (int_ack && win_valid) begin
         irr_n[win_line] = 1'b0;
         isr_n[win_line] = ~aeoi_q;
         if (aeoi_q && rot_q) off_n = win_line + LW'(1);
      end

      // polled read retires the winner
      if (bus_rd && poll_q) begin
         if (win_valid) begin
            irr_n[win_line] = 1'b0;
            isr_n[win_line] = 1'b0;
         end
         poll_n = 1'b0;
      end

      if (init_wr) begin
         imr_n  = '0;
         off_n  = '0;
         smm_n  = 1'b0;
         rsel_n = 1'b0;
         if (!bus_wdata[0]) begin
            sfnm_n = 1'b0;
            aeoi_n = 1'b0;
         end
      end else if (mode_wr) begin
         if (bus_wdata[2]) poll_n = 1'b1;
         if (bus_wdata[1]) rsel_n = bus_wdata[0];
         if (bus_wdata[6]) smm_n  = bus_wdata[5];
      end else if (svc_wr) begin
         case (op)
            OP_ROT_OFF, OP_ROT_ON: rot_n = bus_wdata[7];
            OP_EOI_NS, OP_ROT_NS: begin
               if (top_valid) begin
                  isr_n[top_line] = 1'b0;
                  if (op == OP_ROT_NS) off_n = top_line + LW'(1);
               end
            end
            OP_EOI_SP:  isr_n[cmd_line] = 1'b0;
            OP_SET_PRI: off_n = cmd_line + LW'(1);
            OP_ROT_SP: begin
               isr_n[cmd_line] = 1'b0;
               off_n = cmd_line + LW'(1);
            end
            default: ;
         endcase
      end

      if (odd_wr && seq_run) imr_n  = bus_wdata[LINES-1:0];
      if (ld_base)           base_n = bus_wdata & BASE_MASK;
      if (ld_mode) begin
         sfnm_n = bus_wdata[4];
         aeoi_n = bus_wdata[1];
      end

      irr_n = irr_n | irq_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q <= '0; isr_q <= '0; imr_q <= '0; off_q <= '0; base_q <= '0;
         poll_q <= 1'b0; rsel_q <= 1'b0; smm_q <= 1'b0;
         sfnm_q <= 1'b0; aeoi_q <= 1'b0; rot_q <= 1'b0;
      end else begin
         irr_q <= irr_n; isr_q <= isr_n; imr_q <= imr_n; off_q <= off_n;
         base_q <= base_n; poll_q <= poll_n; rsel_q <= rsel_n; smm_q <= smm_n;
         sfnm_q <= sfnm_n; aeoi_q <= aeoi_n; rot_q <= rot_n;
      end
   end

   a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      init_wr |=> imr_q == '0 && off_q == '0 && !rsel_q && !smm_q);
   a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      odd_wr && seq_run |=> imr_q == $past(bus_wdata[LINES-1:0]));
   a_r5_irq_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irr_q & ~imr_q) != '0);
   a_r6_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack && win_valid && !aeoi_q && !bus_wr && !bus_rd |=> isr_q[$past(win_line)]);
   a_r7_auto_eoi_clear: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack && win_valid && aeoi_q && !bus_wr && !bus_rd |=> !isr_q[$past(win_line)]);
   a_r10_poll_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && poll_q && !bus_wr |=> !poll_q);
   a_r13_strobe_lands: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set != '0 |=> (irr_q & $past(irq_set)) == $past(irq_set));
endmodule

// File: tb/rotpic_core_tb_top.sv
module rotpic_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, int_ack = 1'b0;
   logic [7:0] bus_wdata = '0, irq_set = '0;
   logic [7:0] bus_rdata, int_vector;
   logic       irq_out;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rotpic_core dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_set(irq_set), .irq_out(irq_out), .int_ack(int_ack),
      .int_vector(int_vector)
   );

   // reference state built from the requirements
   logic [7:0] m_irr, m_isr, m_imr, m_base;
   logic [2:0] m_off;
   bit m_poll, m_rsel, m_smm, m_sfnm, m_aeoi, m_rot, m_w4;
   int m_st;
   logic [7:0] s_rd, s_vec;
   bit s_irq;

   function automatic int f_pos(logic [7:0] m, logic [2:0] off);
      for (int p = 0; p < 8; p++)
         if (m[3'(p + int'(off))]) return p;
      return 8;
   endfunction

   function automatic void m_win(output bit v, output logic [2:0] line);
      logic [7:0] eff;
      int pr, cp;
      eff = m_isr;
      if (m_smm) eff = eff & ~m_imr;
      if (m_sfnm) eff[2] = 1'b0;
      pr = f_pos(m_irr & ~m_imr, m_off);
      cp = f_pos(eff, m_off);
      v = pr < cp;
      line = 3'(pr + int'(m_off));
   endfunction

   function automatic void model_step(bit wr, bit rd, bit a, logic [7:0] d,
                                      bit ack, logic [7:0] req);
      bit v;
      logic [2:0] w, tl;
      logic [7:0] n_irr, n_isr;
      logic [2:0] n_off;
      int tp;
      m_win(v, w);
      n_irr = m_irr; n_isr = m_isr; n_off = m_off;
      if (ack && v) begin
         n_irr[w] = 1'b0;
         n_isr[w] = !m_aeoi;
         if (m_aeoi && m_rot) n_off = w + 3'd1;
      end
      if (rd && m_poll) begin
         if (v) begin n_irr[w] = 1'b0; n_isr[w] = 1'b0; end
         m_poll = 1'b0;
      end
      if (wr && !a) begin
         if (d[4]) begin
            m_imr = '0; n_off = '0; m_smm = 0; m_rsel = 0; m_w4 = d[0];
            if (!d[0]) begin m_sfnm = 0; m_aeoi = 0; end
            m_st = 1;
         end else if (d[3]) begin
            if (d[2]) m_poll = 1;
            if (d[1]) m_rsel = d[0];
            if (d[6]) m_smm = d[5];
         end else begin
            case (d[7:5])
               3'd0, 3'd4: m_rot = d[7];
               3'd1, 3'd5: begin
                  tp = f_pos(m_isr, m_off);
                  if (tp != 8) begin
                     tl = 3'(tp + int'(m_off));
                     n_isr[tl] = 1'b0;
                     if (d[7]) n_off = tl + 3'd1;
                  end
               end
               3'd3: n_isr[d[2:0]] = 1'b0;
               3'd6: n_off = d[2:0] + 3'd1;
               3'd7: begin n_isr[d[2:0]] = 1'b0; n_off = d[2:0] + 3'd1; end
               default: ;
            endcase
         end
      end else if (wr && a) begin
         case (m_st)
            0: m_imr = d;
            1: begin m_base = d & 8'hF8; m_st = 2; end
            2: m_st = m_w4 ? 3 : 0;
            default: begin m_sfnm = d[4]; m_aeoi = d[1]; m_st = 0; end
         endcase
      end
      m_irr = n_irr | req; m_isr = n_isr; m_off = n_off;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(bit wr, bit rd, bit a, logic [7:0] d, bit ack, logic [7:0] req);
      bit v;
      logic [2:0] w;
      logic [7:0] e_rd;
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      int_ack = ack; irq_set = req;
      #2;
      s_rd = bus_rdata; s_irq = irq_out; s_vec = int_vector;
      m_win(v, w);
      chk("R5 irq_out vs model", int'(s_irq), int'(v));
      chk("R6 vector vs model", int'(s_vec), int'(m_base | (v ? 8'(w) : 8'd7)));
      if (rd) begin
         if (m_poll) e_rd = v ? (8'h80 | 8'(w)) : 8'h07;
         else if (a) e_rd = m_imr;
         else e_rd = m_rsel ? m_isr : m_irr;
         chk(m_poll ? "R10 poll read vs model" : "R11 read vs model", int'(s_rd), int'(e_rd));
      end
      @(posedge clk);
      model_step(wr, rd, a, d, ack, req);
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = '0; int_ack = 0; irq_set = '0;
   endtask

   task automatic t_wr(bit a, logic [7:0] d); cyc(1, 0, a, d, 0, '0); endtask
   task automatic t_rd(bit a);                cyc(0, 1, a, '0, 0, '0); endtask
   task automatic t_idle();                   cyc(0, 0, 0, '0, 0, '0); endtask
   task automatic t_ack();                    cyc(0, 0, 0, '0, 1, '0); endtask
   task automatic t_req(logic [7:0] m);       cyc(0, 0, 0, '0, 0, m); endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_base = 0; m_off = 0;
      m_poll = 0; m_rsel = 0; m_smm = 0; m_sfnm = 0; m_aeoi = 0; m_rot = 0;
      m_w4 = 0; m_st = 0;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      t_rd(0); chk("R1 reset even read", s_rd, 0); chk("R1 reset irq", s_irq, 0);
      t_rd(1); chk("R1 reset odd read", s_rd, 0); chk("R1 reset vector", s_vec, 8'h07);

      // R2 / R3 initialisation with fourth word
      t_wr(0, 8'h11); t_wr(1, 8'h48); t_wr(1, 8'hFF); t_wr(1, 8'h00);
      t_rd(1); chk("R3 skipped word not in mask", s_rd, 0);
      chk("R6 no winner vector", s_vec, 8'h4F);
      t_req(8'h24);
      t_rd(0); chk("R13 request bits", s_rd, 8'h24);
      chk("R5 lowest position wins", s_vec, 8'h4A); chk("R5 irq high", s_irq, 1);
      t_ack();
      t_wr(0, 8'h0B);
      t_rd(0); chk("R6 ack sets in-service", s_rd, 8'h04);
      chk("R5 lower priority held off", s_irq, 0);
      t_wr(0, 8'h20); t_idle(); chk("R8 nonspecific eoi", s_vec, 8'h4D);
      t_ack(); t_wr(0, 8'hA0); t_req(8'h41);
      t_rd(0); chk("R8 rotate eoi cleared", s_rd, 0); chk("R8 rotate eoi offset", s_vec, 8'h4E);
      t_wr(0, 8'hC6); t_idle(); chk("R9 set priority", s_vec, 8'h48);
      t_ack(); t_idle(); chk("R5 blocked by in-service", s_irq, 0);
      t_wr(0, 8'hE0); t_idle(); chk("R9 specific rotate", s_vec, 8'h4E);
      t_wr(1, 8'h40);
      t_rd(1); chk("R11 mask read", s_rd, 8'h40); chk("R3 masked request", s_irq, 0);
      t_wr(0, 8'h0C); t_rd(0); chk("R10 poll none", s_rd, 8'h07);
      t_rd(0); chk("R10 poll one-shot", s_rd, 8'h00);
      t_wr(1, 8'h00); t_wr(0, 8'h0C); t_rd(0); chk("R10 poll winner", s_rd, 8'h86);
      t_wr(0, 8'h0A); t_rd(0); chk("R10 poll cleared request", s_rd, 8'h00);

      // R7 auto-EOI with rotation
      t_wr(0, 8'h11); t_wr(1, 8'h48); t_wr(1, 8'h00); t_wr(1, 8'h02);
      t_wr(0, 8'h80); t_req(8'h08); t_ack();
      t_wr(0, 8'h0B); t_rd(0); chk("R7 auto-eoi keeps service clear", s_rd, 8'h00);
      t_req(8'h18); t_idle(); chk("R7 rotate on auto-eoi", s_vec, 8'h4C);
      t_ack(); t_ack();

      // R12 special fully nested
      t_wr(0, 8'h11); t_wr(1, 8'h48); t_wr(1, 8'h00); t_wr(1, 8'h10);
      t_req(8'h04); t_ack(); t_req(8'h04);
      t_idle(); chk("R12 cascade line nests", s_vec, 8'h4A);
      // R2 three-word init clears nested mode
      t_wr(0, 8'h10); t_wr(1, 8'h48); t_wr(1, 8'h00);
      t_idle(); chk("R2 nested mode cleared", s_irq, 0);
      // R12 special mask
      t_wr(1, 8'h04); t_wr(0, 8'h68); t_req(8'h08);
      t_idle(); chk("R12 special mask", s_vec, 8'h4B);
      t_wr(0, 8'h48); t_idle(); chk("R4 special mask off", s_irq, 0);
      t_wr(0, 8'h40); t_wr(0, 8'h0B); t_rd(0); chk("R9 nop command", s_rd, 8'h04);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         int op;
         logic [7:0] d, rq;
         op = $urandom % 16;
         d  = 8'($urandom);
         rq = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
         if (op == 0 && ($urandom % 8) != 0) d[4] = 1'b0;
         case (op)
            0, 1, 2:  cyc(1, 0, 0, {d[7:5], 2'b00, d[2:0]}, 0, rq);
            3:        cyc(1, 0, 0, d, 0, rq);
            4, 5:     cyc(1, 0, 0, {d[7:5], 2'b01, d[2:0]}, 0, rq);
            6, 7:     cyc(1, 0, 1, d, 0, rq);
            8, 9, 10: cyc(0, 1, d[0], '0, 0, rq);
            11, 12:   cyc(0, 0, 0, '0, 1, rq);
            default:  cyc(0, 0, 0, '0, 0, rq);
         endcase
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule